// File: doc/BRIEF.md
# Data Access Permission and Fault Checker

This block sits beside a translation lookaside buffer in a processor's load/store path. It classifies every data read or write using three things: the 32-bit virtual address, whether the access comes from privileged or user mode, and a few control bits. Each access ends up in one of four outcomes:

- a direct pass-through;
- an unmapped store-queue access;
- a mapped access that needs a lookup;
- a fault.

For mapped accesses, the checker asks the external TLB for a lookup in the same cycle, with or without address-space matching. The TLB returns a hit, a miss or a multi-hit, along with the entry's physical page, size and permission flags. The checker then applies the protection and dirty-page rules and forms the physical address.

All outcomes are registered. One cycle after a request, the block presents the route, the physical address and a one-hot fault vector. A fault strobe lasts a single cycle. When the fault involves the TLB, the faulting virtual address is captured, together with a page-table-entry-high value. That value takes its upper bits from the address and keeps its lower ten bits from the current register value.

Top module: `data_access_guard`

## Requirements
- R1: In privileged mode with address bit 31 set, an address at or above 0xE0000000 passes unchanged (route 0). An address below 0xC0000000 passes with bits 31:29 cleared (route 0). Addresses from 0xC0000000 up to 0xDFFFFFFF take the translation path.
- R2: In user mode with address bit 31 set, an address in 0xE0000000..0xE3FFFFFF passes unchanged as a store-queue access (route 1), but only when `ctl_sq_lock` is 0. Every other such address faults with fault bit 0 (read address error) or fault bit 1 (write address error).
- R3: For an address on the translation path, when `ctl_xlat_en` is 0 the address passes with bits 31:29 cleared (route 0), and no lookup is requested.
- R4: `lkp_req` is high, combinationally, exactly when a valid request needs a TLB lookup. `lkp_use_asid` is low only when `ctl_single_space` and `req_priv` are both 1.
- R5: A TLB multi-hit gives fault bit 4, and takes precedence over everything else. A miss gives fault bit 2 for a read or fault bit 3 for a write.
- R6: A user-mode read that hits an entry with `tlb_user` = 0 gives fault bit 5 (read protection).
- R7: A write gives fault bit 6 (write protection) in two cases: a privileged write to an entry with `tlb_writable` = 0, or a user write to an entry that lacks either `tlb_writable` or `tlb_user`.
- R8: A write that passes protection to an entry with `tlb_dirty` = 0 gives fault bit 7 (initial page write).
- R9: A successful mapped access (route 2) forms the physical address from two parts. The upper part is the page number `tlb_ppn` (physical bits 28:10), masked by the page size. The lower part is the virtual address bits outside the mask. The `tlb_size` codes are 0 = 1 KiB, 1 = 4 KiB, 2 = 64 KiB and 3 = 1 MiB.
- R10: A mapped physical address strictly greater than 0x1C000000 is ORed with 0xE0000000. An address equal to 0x1C000000 is left as it is.
- R11: On a fault with any of bits 2..7, `fault_addr` captures the virtual address. At the same time, `pteh_out` takes address bits 31:10 and bits 9:0 of `pteh_in`. Address errors and successful accesses leave both unchanged.
- R12: `rsp_valid` rises exactly one cycle after `req_valid`. `rsp_fault` has at most one bit set. When it is non-zero, the route is 3 and `rsp_paddr` is 0. `fault_valid` is high for the single response cycle of a faulting access.
- R13: After reset, `rsp_valid`, `fault_valid`, `rsp_fault`, `rsp_paddr`, `fault_addr` and `pteh_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_vaddr | input | 32 | Virtual address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| ctl_xlat_en | input | 1 | Address translation enabled |
| ctl_sq_lock | input | 1 | 1 = user mode may not use the store-queue window |
| ctl_single_space | input | 1 | Single virtual space: privileged lookups ignore ASID |
| pteh_in | input | 32 | Current page-table-entry-high register value |
| lkp_req | output | 1 | TLB lookup requested (combinational) |
| lkp_use_asid | output | 1 | TLB lookup must match ASID (combinational) |
| tlb_hit | input | 1 | TLB found exactly one matching entry |
| tlb_multi | input | 1 | TLB found more than one matching entry |
| tlb_ppn | input | 19 | Physical page number, physical bits 28:10 |
| tlb_size | input | 2 | Page size code of the matched entry |
| tlb_user | input | 1 | Entry accessible from user mode |
| tlb_writable | input | 1 | Entry writable |
| tlb_dirty | input | 1 | Entry already written |
| rsp_valid | output | 1 | Registered response valid |
| rsp_route | output | 2 | 0 direct, 1 store queue, 2 mapped, 3 fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 8 | One-hot fault code |
| fault_valid | output | 1 | Single-cycle fault strobe |
| fault_addr | output | 32 | Captured faulting virtual address |
| pteh_out | output | 32 | Captured page-table-entry-high value |

## Verification
Several situations are hard to reach by chance because they need an unusual combination at once. One is the initial-page-write fault, which needs a write that hits, is permitted in the current mode and lands on a clean page. Another is the remap boundary, which needs a page number whose masked physical address lands exactly on or just above 0x1C000000. The stimulus mixes biased random accesses, with region-weighted addresses and random TLB answers, with directed accesses that force these combinations. Every access is followed by an idle cycle, to show that the fault strobe drops and the captured address holds.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int VA_W     = 32;
    localparam int PAGE_LSB = 10;
    localparam int PPN_W    = 29 - PAGE_LSB;
    localparam int FAULT_W  = 8;
    localparam int ROUTE_W  = 2;
    localparam int SIZE_W   = 2;

    localparam logic [VA_W-1:0] TOP_BASE    = 32'hE000_0000;
    localparam logic [VA_W-1:0] MAP_BASE    = 32'hC000_0000;
    localparam logic [VA_W-1:0] SQ_END      = 32'hE400_0000;
    localparam logic [VA_W-1:0] EXT_MASK    = 32'h1FFF_FFFF;
    localparam logic [VA_W-1:0] REMAP_LIMIT = 32'h1C00_0000;

    // fault vector bit positions
    localparam int FB_RADDR  = 0;
    localparam int FB_WADDR  = 1;
    localparam int FB_RMISS  = 2;
    localparam int FB_WMISS  = 3;
    localparam int FB_MULTI  = 4;
    localparam int FB_RPROT  = 5;
    localparam int FB_WPROT  = 6;
    localparam int FB_INITWR = 7;

    localparam logic [FAULT_W-1:0] TLB_FAULTS = 8'b1111_1100;

    typedef enum logic [2:0] {
        REG_KEEP,
        REG_CLEAR,
        REG_SQ,
        REG_MAP,
        REG_AERR
    } region_e;

    typedef enum logic [ROUTE_W-1:0] {
        RT_DIRECT = 2'd0,
        RT_SQUEUE = 2'd1,
        RT_MAPPED = 2'd2,
        RT_FAULT  = 2'd3
    } route_e;

    typedef struct packed {
        route_e             route;
        logic [VA_W-1:0]    paddr;
        logic [FAULT_W-1:0] fault;
    } result_t;

    function automatic logic [VA_W-1:0] page_mask(input logic [SIZE_W-1:0] sz);
        case (sz)
            2'd0:    page_mask = 32'hFFFF_FC00;
            2'd1:    page_mask = 32'hFFFF_F000;
            2'd2:    page_mask = 32'hFFFF_0000;
            default: page_mask = 32'hFFF0_0000;
        endcase
    endfunction

    function automatic logic [FAULT_W-1:0] fault_bit(input int idx);
        fault_bit = '0;
        fault_bit[idx] = 1'b1;
    endfunction

endpackage

// File: rtl/dag_region.sv
module dag_region
    import dag_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic            priv,
    input  logic            sq_lock,
    input  logic            xlat_en,
    output region_e         region
);
    logic high_half;
    logic in_top;
    logic below_map;
    logic in_sq_win;

    assign high_half = vaddr[VA_W-1];
    assign in_top    = (vaddr >= TOP_BASE);
    assign below_map = (vaddr < MAP_BASE);
    assign in_sq_win = in_top && (vaddr < SQ_END);

    always_comb begin
        region = xlat_en ? REG_MAP : REG_CLEAR;
        if (high_half) begin
            if (priv) begin
                if (in_top)
                    region = REG_KEEP;
                else if (below_map)
                    region = REG_CLEAR;
            end else begin
                region = (in_sq_win && !sq_lock) ? REG_SQ : REG_AERR;
            end
        end
    end
endmodule

// File: rtl/dag_prot.sv
module dag_prot
    import dag_pkg::*;
(
    input  logic               hit,
    input  logic               multi,
    input  logic               write,
    input  logic               priv,
    input  logic               e_user,
    input  logic               e_writable,
    input  logic               e_dirty,
    output logic [FAULT_W-1:0] fault
);
    logic wr_denied;

    assign wr_denied = priv ? !e_writable : !(e_writable && e_user);

    // priority: multi-hit, miss, protection, clean page
    always_comb begin
        fault = '0;
        if (multi)
            fault = fault_bit(FB_MULTI);
        else if (!hit)
            fault = write ? fault_bit(FB_WMISS) : fault_bit(FB_RMISS);
        else if (!write && !priv && !e_user)
            fault = fault_bit(FB_RPROT);
        else if (write && wr_denied)
            fault = fault_bit(FB_WPROT);
        else if (write && !e_dirty)
            fault = fault_bit(FB_INITWR);
    end
endmodule

// File: rtl/dag_paddr.sv
module dag_paddr
    import dag_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr,
    input  logic [PPN_W-1:0]  ppn,
    input  logic [SIZE_W-1:0] size,
    output logic [VA_W-1:0]   paddr
);
    localparam int HI_PAD = VA_W - PPN_W - PAGE_LSB;

    logic [VA_W-1:0] mask;
    logic [VA_W-1:0] frame;
    logic [VA_W-1:0] joined;

    assign mask   = page_mask(size);
    assign frame  = {{HI_PAD{1'b0}}, ppn, {PAGE_LSB{1'b0}}};
    assign joined = (frame & mask) | (vaddr & ~mask);
    assign paddr  = (joined > REMAP_LIMIT) ? (joined | TOP_BASE) : joined;
endmodule

// File: rtl/data_access_guard.sv
module data_access_guard
    import dag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    input  logic                  req_priv,
    input  logic                  ctl_xlat_en,
    input  logic                  ctl_sq_lock,
    input  logic                  ctl_single_space,
    input  logic [VA_W-1:0]       pteh_in,
    output logic                  lkp_req,
    output logic                  lkp_use_asid,
    input  logic                  tlb_hit,
    input  logic                  tlb_multi,
    input  logic [PPN_W-1:0]      tlb_ppn,
    input  logic [SIZE_W-1:0]     tlb_size,
    input  logic                  tlb_user,
    input  logic                  tlb_writable,
    input  logic                  tlb_dirty,
    output logic                  rsp_valid,
    output logic [ROUTE_W-1:0]    rsp_route,
    output logic [VA_W-1:0]       rsp_paddr,
    output logic [FAULT_W-1:0]    rsp_fault,
    output logic                  fault_valid,
    output logic [VA_W-1:0]       fault_addr,
    output logic [VA_W-1:0]       pteh_out
);
    region_e            region;
    logic [FAULT_W-1:0] map_fault;
    logic [VA_W-1:0]    map_paddr;
    result_t            nxt;
    result_t            cur;
    logic               tlb_capture;

    dag_region u_region (
        .vaddr   (req_vaddr),
        .priv    (req_priv),
        .sq_lock (ctl_sq_lock),
        .xlat_en (ctl_xlat_en),
        .region  (region)
    );

    dag_prot u_prot (
        .hit        (tlb_hit),
        .multi      (tlb_multi),
        .write      (req_write),
        .priv       (req_priv),
        .e_user     (tlb_user),
        .e_writable (tlb_writable),
        .e_dirty    (tlb_dirty),
        .fault      (map_fault)
    );

    dag_paddr u_paddr (
        .vaddr (req_vaddr),
        .ppn   (tlb_ppn),
        .size  (tlb_size),
        .paddr (map_paddr)
    );

    assign lkp_req      = req_valid && (region == REG_MAP);
    assign lkp_use_asid = !(ctl_single_space && req_priv);

    always_comb begin
        nxt = '{route: RT_FAULT, paddr: '0, fault: '0};
        case (region)
            REG_KEEP:  nxt = '{route: RT_DIRECT, paddr: req_vaddr, fault: '0};
            REG_CLEAR: nxt = '{route: RT_DIRECT, paddr: req_vaddr & EXT_MASK, fault: '0};
            REG_SQ:    nxt = '{route: RT_SQUEUE, paddr: req_vaddr, fault: '0};
            REG_AERR:  nxt.fault = req_write ? fault_bit(FB_WADDR) : fault_bit(FB_RADDR);
            REG_MAP: begin
                if (map_fault != '0)
                    nxt.fault = map_fault;
                else
                    nxt = '{route: RT_MAPPED, paddr: map_paddr, fault: '0};
            end
            default: nxt = '{route: RT_FAULT, paddr: '0, fault: '0};
        endcase
    end

    assign tlb_capture = req_valid && ((nxt.fault & TLB_FAULTS) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            cur         <= '{route: RT_DIRECT, paddr: '0, fault: '0};
            fault_valid <= 1'b0;
            fault_addr  <= '0;
            pteh_out    <= '0;
        end else begin
            rsp_valid   <= req_valid;
            fault_valid <= req_valid && (nxt.fault != '0);
            if (req_valid)
                cur <= nxt;
            if (tlb_capture) begin
                fault_addr <= req_vaddr;
                pteh_out   <= {req_vaddr[VA_W-1:PAGE_LSB], pteh_in[PAGE_LSB-1:0]};
            end
        end
    end

    assign rsp_route = cur.route;
    assign rsp_paddr = cur.paddr;
    assign rsp_fault = cur.fault;

    // R12: response follows the request by one cycle, fault code one-hot
    a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));
    a_r12_fault_onehot: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0(rsp_fault));
    a_r12_strobe_in_rsp: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (rsp_valid && rsp_route == RT_FAULT && rsp_paddr == '0));
    // R11: capture on TLB-class fault, hold otherwise
    a_r11_capture_va: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault & TLB_FAULTS) != '0) |-> (fault_addr == $past(req_vaddr)));
    a_r11_keep_low_pteh: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault & TLB_FAULTS) != '0)
            |-> (pteh_out[PAGE_LSB-1:0] == $past(pteh_in[PAGE_LSB-1:0])));
    a_r11_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && (rsp_fault & TLB_FAULTS) != '0) |-> $stable(fault_addr));
    // R8: clean-page fault only on writes
    a_r8_initwr_is_write: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault[FB_INITWR]) |-> $past(req_write));
    // R6: read protection only for user reads
    a_r6_rprot_user_read: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault[FB_RPROT]) |-> ($past(!req_priv) && $past(!req_write)));
endmodule

// File: tb/data_access_guard_tb.sv
module data_access_guard_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_priv;
    logic [31:0] req_vaddr, pteh_in;
    logic        ctl_xlat_en, ctl_sq_lock, ctl_single_space;
    logic        lkp_req, lkp_use_asid;
    logic        tlb_hit, tlb_multi, tlb_user, tlb_writable, tlb_dirty;
    logic [18:0] tlb_ppn;
    logic [1:0]  tlb_size;
    logic        rsp_valid, fault_valid;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_paddr, fault_addr, pteh_out;
    logic [7:0]  rsp_fault;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_faddr = '0;
    logic [31:0] exp_pteh  = '0;

    always #5 clk = ~clk;

    data_access_guard u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_priv(req_priv), .ctl_xlat_en(ctl_xlat_en),
        .ctl_sq_lock(ctl_sq_lock), .ctl_single_space(ctl_single_space),
        .pteh_in(pteh_in), .lkp_req(lkp_req), .lkp_use_asid(lkp_use_asid),
        .tlb_hit(tlb_hit), .tlb_multi(tlb_multi), .tlb_ppn(tlb_ppn),
        .tlb_size(tlb_size), .tlb_user(tlb_user), .tlb_writable(tlb_writable),
        .tlb_dirty(tlb_dirty), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .fault_valid(fault_valid),
        .fault_addr(fault_addr), .pteh_out(pteh_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // Reference model built from the requirement text
    task automatic model(output logic [31:0] pa, output logic [7:0] f,
                         output logic [1:0] rt, output logic lk, output string tag);
        logic [31:0] va, m, pm;
        va = req_vaddr; pa = '0; f = '0; rt = 2'd3; lk = 1'b0; tag = "R12";
        if (va[31] && req_priv && va >= 32'hE000_0000) begin
            pa = va; rt = 2'd0; tag = "R1";
        end else if (va[31] && req_priv && va < 32'hC000_0000) begin
            pa = va & 32'h1FFF_FFFF; rt = 2'd0; tag = "R1";
        end else if (va[31] && !req_priv) begin
            tag = "R2";
            if (va >= 32'hE000_0000 && va < 32'hE400_0000 && !ctl_sq_lock) begin
                pa = va; rt = 2'd1;
            end else f = req_write ? 8'h02 : 8'h01;
        end else if (!ctl_xlat_en) begin
            pa = va & 32'h1FFF_FFFF; rt = 2'd0; tag = "R3";
        end else begin
            lk = 1'b1;
            if (tlb_multi) begin f = 8'h10; tag = "R5"; end
            else if (!tlb_hit) begin f = req_write ? 8'h08 : 8'h04; tag = "R5"; end
            else if (!req_write && !req_priv && !tlb_user) begin f = 8'h20; tag = "R6"; end
            else if (req_write && (req_priv ? !tlb_writable : !(tlb_writable && tlb_user))) begin
                f = 8'h40; tag = "R7";
            end else if (req_write && !tlb_dirty) begin f = 8'h80; tag = "R8"; end
            else begin
                case (tlb_size)
                    2'd0: m = 32'hFFFF_FC00;
                    2'd1: m = 32'hFFFF_F000;
                    2'd2: m = 32'hFFFF_0000;
                    default: m = 32'hFFF0_0000;
                endcase
                pm = ({13'd0, tlb_ppn} << 10) & m | (va & ~m);
                tag = "R9";
                if (pm > 32'h1C00_0000) begin pm = pm | 32'hE000_0000; tag = "R10"; end
                pa = pm; rt = 2'd2;
            end
        end
    endtask

    // drive at a falling edge; check combinational and registered outputs
    task automatic access();
        logic [31:0] pa; logic [7:0] f; logic [1:0] rt; logic lk; string tag;
        logic [31:0] va;
        req_valid = 1'b1;
        model(pa, f, rt, lk, tag);
        va = req_vaddr;
        #1;
        chk("R4", "lkp_req", {31'd0, lkp_req}, {31'd0, lk});
        chk("R4", "lkp_use_asid", {31'd0, lkp_use_asid},
            {31'd0, !(ctl_single_space && req_priv)});
        if ((f & 8'hFC) != 0) begin
            exp_faddr = va;
            exp_pteh  = {va[31:10], pteh_in[9:0]};
        end
        @(posedge clk); #2;
        chk("R12", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(tag, "route", {30'd0, rsp_route}, {30'd0, rt});
        chk(tag, "paddr", rsp_paddr, pa);
        chk(tag, "fault", {24'd0, rsp_fault}, {24'd0, f});
        chk("R12", "fault_valid", {31'd0, fault_valid}, {31'd0, f != 0});
        chk("R11", "fault_addr", fault_addr, exp_faddr);
        chk("R11", "pteh_out", pteh_out, exp_pteh);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = $urandom;
        @(posedge clk); #2;
        chk("R12", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R12", "idle fault_valid", {31'd0, fault_valid}, 32'd0);
        chk("R11", "idle fault_addr", fault_addr, exp_faddr);
        @(negedge clk);
    endtask

    task automatic set_req(input logic [31:0] va, input logic w, input logic p);
        req_vaddr = va; req_write = w; req_priv = p;
    endtask

    task automatic set_tlb(input logic h, input logic mh, input logic [18:0] pn,
                           input logic [1:0] sz, input logic u, input logic wr,
                           input logic d);
        tlb_hit = h; tlb_multi = mh; tlb_ppn = pn; tlb_size = sz;
        tlb_user = u; tlb_writable = wr; tlb_dirty = d;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 1'b0; set_req(32'h0, 1'b0, 1'b0);
        pteh_in = 32'h0000_03A5; ctl_xlat_en = 1'b1; ctl_sq_lock = 1'b0;
        ctl_single_space = 1'b0;
        set_tlb(1'b0, 1'b0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        chk("R13", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R13", "fault_valid", {31'd0, fault_valid}, 32'd0);
        chk("R13", "rsp_fault", {24'd0, rsp_fault}, 32'd0);
        chk("R13", "rsp_paddr", rsp_paddr, 32'd0);
        chk("R13", "fault_addr", fault_addr, 32'd0);
        chk("R13", "pteh_out", pteh_out, 32'd0);

        // R1: privileged top region and low-cleared region
        set_req(32'hF000_1234, 1'b0, 1'b1); access();
        chk("R1", "literal top", rsp_paddr, 32'hF000_1234);
        set_req(32'hA500_0010, 1'b1, 1'b1); access();
        chk("R1", "literal clear", rsp_paddr, 32'h0500_0010);
        // R2: user store-queue window and address errors
        set_req(32'hE100_0040, 1'b1, 1'b0); access();
        ctl_sq_lock = 1'b1;
        set_req(32'hE100_0040, 1'b0, 1'b0); access();
        ctl_sq_lock = 1'b0;
        set_req(32'hE400_0000, 1'b1, 1'b0); access();
        set_req(32'h9000_0000, 1'b1, 1'b0); access();
        // R3: translation disabled
        ctl_xlat_en = 1'b0;
        set_req(32'hC123_4567, 1'b0, 1'b1); access();
        chk("R3", "literal", rsp_paddr, 32'h0123_4567);
        set_req(32'h7234_5678, 1'b1, 1'b0); access();
        ctl_xlat_en = 1'b1;
        // R4: asid-free lookup only in privileged single-space mode
        ctl_single_space = 1'b1;
        set_tlb(1'b0, 1'b0, '0, 2'd0, 1'b1, 1'b1, 1'b1);
        set_req(32'hC000_0000, 1'b0, 1'b1); access();
        set_req(32'h0000_1000, 1'b0, 1'b0); access();
        ctl_single_space = 1'b0;
        // R5: miss read, miss write, multi-hit over hit
        set_req(32'h0040_0000, 1'b1, 1'b0); access();
        set_tlb(1'b1, 1'b1, 19'h00100, 2'd1, 1'b1, 1'b1, 1'b1); access();
        // R6: user read without user flag
        set_tlb(1'b1, 1'b0, 19'h00100, 2'd1, 1'b0, 1'b1, 1'b1);
        set_req(32'h0040_0123, 1'b0, 1'b0); access();
        // R7: privileged write not writable; user write lacking user flag
        set_tlb(1'b1, 1'b0, 19'h00100, 2'd1, 1'b1, 1'b0, 1'b1);
        set_req(32'h0040_0123, 1'b1, 1'b1); access();
        set_tlb(1'b1, 1'b0, 19'h00100, 2'd1, 1'b0, 1'b1, 1'b1);
        set_req(32'h0040_0123, 1'b1, 1'b0); access();
        // R8: clean page write
        set_tlb(1'b1, 1'b0, 19'h00100, 2'd1, 1'b1, 1'b1, 1'b0); access();
        // R11: address error after TLB fault leaves captured values
        pteh_in = 32'hFFFF_FC11;
        set_req(32'hD000_0000, 1'b0, 1'b0); access();
        // R9: 4 KiB and 1 MiB mappings
        set_tlb(1'b1, 1'b0, 19'h00123, 2'd1, 1'b1, 1'b1, 1'b1);
        set_req(32'h1234_5ABC, 1'b1, 1'b0); access();
        chk("R9", "literal 4K", rsp_paddr, 32'h0004_8ABC);
        set_tlb(1'b1, 1'b0, 19'h04C00, 2'd3, 1'b1, 1'b1, 1'b1);
        set_req(32'h0ABC_DEF0, 1'b0, 1'b1); access();
        chk("R9", "literal 1M", rsp_paddr, 32'h013C_DEF0);
        // R10: boundary equal not remapped, just above remapped
        set_tlb(1'b1, 1'b0, 19'h70000, 2'd0, 1'b1, 1'b1, 1'b1);
        set_req(32'h0000_0000, 1'b0, 1'b1); access();
        chk("R10", "equal", rsp_paddr, 32'h1C00_0000);
        set_req(32'h0000_0004, 1'b0, 1'b1); access();
        chk("R10", "above", rsp_paddr, 32'hFC00_0004);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [2:0] top;
            top = 3'($urandom);
            req_vaddr = {top, 29'($urandom)};
            if ($urandom % 4 == 0) req_vaddr = {6'b111000, 26'($urandom)};
            req_write = 1'($urandom); req_priv = 1'($urandom);
            ctl_xlat_en = ($urandom % 6) != 0; ctl_sq_lock = 1'($urandom);
            ctl_single_space = 1'($urandom); pteh_in = $urandom;
            tlb_multi = ($urandom % 10) == 0; tlb_hit = ($urandom % 5) != 0;
            tlb_ppn = 19'($urandom); tlb_size = 2'($urandom);
            tlb_user = ($urandom % 4) != 0; tlb_writable = ($urandom % 4) != 0;
            tlb_dirty = ($urandom % 3) != 0;
            access();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule